// File: doc/BRIEF.md
# Maskable Interrupt Status Register

This block is the interrupt status and control register of a network controller. Five event sources report into it: a received frame lost for lack of buffers, a bus request that went unanswered for too long, receive completion, transmit completion and the end of initialization. Each event is caught in a sticky status bit that stays set until the host writes a 1 to it. Per-source mask bits and a global enable decide which of the held events pull the active-low interrupt line low. Two summary bits are also provided. One shows that any unmasked event is pending. The other shows that an error-class event is held, whatever the masks are.

Each source has its own qualifying rule. Receive completion can be reported early, on the first buffer of a frame, when early reporting is enabled. Transmit completion can be suppressed for frames that went out without error. The grant-timeout event comes from a built-in watchdog. It measures, in microseconds, how long the bus request has been waiting without a grant. A three-word register port stands in for the host bus.

Register map (32-bit words). Word 0 is control/status: bit 0 is the global enable (read/write), bit 1 is the stop action (write 1, reads 0), bit 2 is the pending flag (read-only), bit 3 is the error summary (read-only), and bits 12..8 are the status bits (write 1 to clear). Word 1 is configuration: bit 0 is early receive reporting, bit 1 is transmit-success suppression, and bits 12..8 are the mask bits. Word 2 is the grant timeout in microseconds. Status and mask positions are shared: bit 12 lost frame, bit 11 grant timeout, bit 10 receive done, bit 9 transmit done, bit 8 initialization done.

Top module: `irq_status_reg`

## Requirements
- R1: After reset every status bit, the global enable, every mask bit and both qualifier bits read 0, the timeout word reads its default of 153600, and irq_n is 1.
- R2: Writing 1 to a status bit in word 0 clears it. Writing 0 leaves it unchanged.
- R3: When a source event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R4: Writing 1 to word 0 bit 1 (stop), or pulsing soft_rst, clears all five status bits. A write to word 0 also loads the global enable from bit 0.
- R5: irq_n goes to 0 one cycle after a status bit is set while the global enable is 1 and that source's mask bit (word 1, same bit position) is 0. It stays 1 while the enable is 0 or the source is masked.
- R6: The pending flag (word 0 bit 2) is 1 exactly when some status bit is set with its mask bit 0, whatever the global enable is.
- R7: The error summary (word 0 bit 3) is 1 whenever the lost-frame bit (12) or the grant-timeout bit (11) is set, whatever the masks and the global enable are.
- R8: The receive-done bit (10) is set by ev_rx_last. ev_rx_first sets it only when early receive reporting (word 1 bit 0) is 1.
- R9: The transmit-done bit (9) is set by ev_tx_done, unless word 1 bit 1 is 1 and ev_tx_ok is 1 in that cycle.
- R10: ev_init_done sets bit 8 and ev_miss sets bit 12.
- R11: The grant-timeout bit (11) is set once bus_req has been held without bus_gnt for the timeout word's count of microseconds. Dropping the request or receiving a grant restarts the count. Each wait sets the bit at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset pulse; clears status bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word select for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register word select for reads |
| rd_data | output | 32 | Read data (combinational) |
| ev_miss | input | 1 | Receive frame lost pulse |
| ev_rx_first | input | 1 | First receive buffer returned pulse |
| ev_rx_last | input | 1 | Last receive buffer returned pulse |
| ev_tx_done | input | 1 | Last transmit buffer returned pulse |
| ev_tx_ok | input | 1 | Qualifies ev_tx_done: frame sent without error |
| ev_init_done | input | 1 | Initialization complete pulse |
| bus_req | input | 1 | Controller bus request |
| bus_gnt | input | 1 | Bus grant |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The interrupt path is driven by each source in turn, under three settings: masks open with the enable on, the enable off, and one source masked. This tells a wrong bit position apart from a missing gate. Receive and transmit events are sent with the qualifier bits both 0 and 1, which separates the early-report and suppression rules from the plain set path. The watchdog is given an uninterrupted wait, a wait broken by a grant, and a request left high after the bit was cleared. These show the threshold, the restart and the once-only behaviour separately. A set and a clear that land together, and the stop and soft-reset paths, cover the ordering of the clear sources.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared constants for the interrupt status register: source indices,
// the bit offset where status and mask fields start, and register words.
package irq_pkg;
    localparam int NSRC     = 5;
    localparam int SRC_LSB  = 8;
    // Index of each source inside the 5-bit status/mask vectors.
    localparam int SRC_IDON = 0;
    localparam int SRC_TINT = 1;
    localparam int SRC_RINT = 2;
    localparam int SRC_MERR = 3;
    localparam int SRC_MISS = 4;

    typedef enum logic [1:0] {
        W_CTRL = 2'd0,
        W_CFG  = 2'd1,
        W_TMO  = 2'd2
    } reg_word_e;
endpackage

// File: rtl/irq_sticky_bit.sv
// Module irq_sticky_bit
// One sticky status bit. A set pulse wins over a same-cycle host clear.
// A kill (stop or soft reset) wins over everything.
// Assumes: all inputs synchronous to clk.
module irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, set or clear the status bit.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            q <= 1'b0;
        end else begin
            q <= set | (q & ~clr);
        end
    end

    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !kill) |=> q);
    a_r4_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !q);
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set && !kill) |=> !q);
    a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr && !set && !kill) |=> q);
endmodule

// File: rtl/irq_grant_watchdog.sv
// Module irq_grant_watchdog
// Measures how long a bus request has waited without a grant, in
// microseconds, using a prescaler of CLK_MHZ cycles. It emits a one-cycle
// fire pulse when the wait reaches tmo_us. A timeout of 0 never fires.
// Assumes: CLK_MHZ >= 2. Dropping the request or a grant restarts the count.
module irq_grant_watchdog #(
    parameter int CLK_MHZ = 125,
    parameter int TMO_W   = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_gnt,
    input  logic [TMO_W-1:0] tmo_us,
    output logic             fire
);
    localparam int            PRE_W   = $clog2(CLK_MHZ);
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_MHZ - 1);

    logic             waiting;
    logic [PRE_W-1:0] pre_q;
    logic [TMO_W-1:0] us_q;
    logic             fired_q;
    logic             reached;

    assign waiting = bus_req & ~bus_gnt;
    assign reached = (us_q >= tmo_us);
    assign fire    = waiting & ~fired_q & (tmo_us != '0) & reached;

    // Count microseconds of ungranted request; freeze once the limit is met.
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting) begin
            pre_q   <= '0;
            us_q    <= '0;
            fired_q <= 1'b0;
        end else begin
            if (fire) begin
                fired_q <= 1'b1;
            end
            if (!reached) begin
                if (pre_q == PRE_MAX) begin
                    pre_q <= '0;
                    us_q  <= us_q + 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    a_r11_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    a_r11_grant_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> !fire);
endmodule

// File: rtl/irq_event_qualify.sv
// Module irq_event_qualify
// Turns raw controller event pulses into per-source set pulses, applying
// the early-receive and transmit-success suppression rules.
// Assumes: event inputs are single-cycle pulses.
module irq_event_qualify
    import irq_pkg::*;
(
    input  logic            ev_miss,
    input  logic            ev_rx_first,
    input  logic            ev_rx_last,
    input  logic            ev_tx_done,
    input  logic            ev_tx_ok,
    input  logic            ev_init_done,
    input  logic            wd_fire,
    input  logic            early_rx_en,
    input  logic            tx_ok_quiet,
    output logic [NSRC-1:0] set_vec
);
    // Map each qualified event onto its status index.
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_MISS] = ev_miss;
        set_vec[SRC_MERR] = wd_fire;
        set_vec[SRC_RINT] = ev_rx_last | (ev_rx_first & early_rx_en);
        set_vec[SRC_TINT] = ev_tx_done & ~(tx_ok_quiet & ev_tx_ok);
        set_vec[SRC_IDON] = ev_init_done;
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module irq_status_reg
// Interrupt status/control register: five sticky sources with write-1-to-
// clear, per-source masks, global enable, pending and error summaries, a
// grant-timeout watchdog and a registered active-low interrupt output.
// Assumes: DATA_W >= 13 and TMO_W <= DATA_W; synchronous active-low reset.
module irq_status_reg
    import irq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TMO_W   = 18,
    parameter int CLK_MHZ = 125,
    parameter int TMO_DEF = 153600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_miss,
    input  logic              ev_rx_first,
    input  logic              ev_rx_last,
    input  logic              ev_tx_done,
    input  logic              ev_tx_ok,
    input  logic              ev_init_done,
    input  logic              bus_req,
    input  logic              bus_gnt,
    output logic              irq_n
);
    localparam int SRC_MSB = SRC_LSB + NSRC - 1;

    logic              iena_q;
    logic [NSRC-1:0]   mask_q;
    logic              early_rx_q;
    logic              tx_quiet_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [NSRC-1:0]   status;
    logic [NSRC-1:0]   set_vec;
    logic [NSRC-1:0]   clr_vec;
    logic              wd_fire;
    logic              wr_ctrl;
    logic              wr_cfg;
    logic              wr_tmo;
    logic              kill;
    logic              intr;
    logic              err;

    assign wr_ctrl = wr_en && (wr_addr == W_CTRL);
    assign wr_cfg  = wr_en && (wr_addr == W_CFG);
    assign wr_tmo  = wr_en && (wr_addr == W_TMO);
    assign kill    = soft_rst | (wr_ctrl & wr_data[1]);
    assign clr_vec = wr_ctrl ? wr_data[SRC_MSB:SRC_LSB] : '0;
    assign intr    = |(status & ~mask_q);
    assign err     = status[SRC_MISS] | status[SRC_MERR];

    // Host-writable control and configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iena_q     <= 1'b0;
            mask_q     <= '0;
            early_rx_q <= 1'b0;
            tx_quiet_q <= 1'b0;
            tmo_q      <= TMO_W'(TMO_DEF);
        end else begin
            if (wr_ctrl) begin
                iena_q <= wr_data[0];
            end
            if (wr_cfg) begin
                early_rx_q <= wr_data[0];
                tx_quiet_q <= wr_data[1];
                mask_q     <= wr_data[SRC_MSB:SRC_LSB];
            end
            if (wr_tmo) begin
                tmo_q <= wr_data[TMO_W-1:0];
            end
        end
    end

    // Registered active-low interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else begin
            irq_n <= ~(iena_q & intr);
        end
    end

    // Read multiplexer over the three register words.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            W_CTRL: begin
                rd_data[0]               = iena_q;
                rd_data[2]               = intr;
                rd_data[3]               = err;
                rd_data[SRC_MSB:SRC_LSB] = status;
            end
            W_CFG: begin
                rd_data[0]               = early_rx_q;
                rd_data[1]               = tx_quiet_q;
                rd_data[SRC_MSB:SRC_LSB] = mask_q;
            end
            W_TMO:   rd_data[TMO_W-1:0] = tmo_q;
            default: rd_data = '0;
        endcase
    end

    irq_grant_watchdog #(
        .CLK_MHZ (CLK_MHZ),
        .TMO_W   (TMO_W)
    ) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_req (bus_req),
        .bus_gnt (bus_gnt),
        .tmo_us  (tmo_q),
        .fire    (wd_fire)
    );

    irq_event_qualify u_qual (
        .ev_miss      (ev_miss),
        .ev_rx_first  (ev_rx_first),
        .ev_rx_last   (ev_rx_last),
        .ev_tx_done   (ev_tx_done),
        .ev_tx_ok     (ev_tx_ok),
        .ev_init_done (ev_init_done),
        .wd_fire      (wd_fire),
        .early_rx_en  (early_rx_q),
        .tx_ok_quiet  (tx_quiet_q),
        .set_vec      (set_vec)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .kill  (kill),
            .set   (set_vec[i]),
            .clr   (clr_vec[i]),
            .q     (status[i])
        );
    end

    a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (iena_q && |(status & ~mask_q)) |=> !irq_n);
    a_r5_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !iena_q |=> irq_n);
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_fire && !kill) |=> (rd_addr != W_CTRL) || rd_data[3]);
endmodule

// File: tb/irq_status_reg_tb.sv
`timescale 1ns/1ps
module irq_status_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        ev_miss = 0, ev_rx_first = 0, ev_rx_last = 0;
    logic        ev_tx_done = 0, ev_tx_ok = 0, ev_init_done = 0;
    logic        bus_req = 0, bus_gnt = 0;
    logic        irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    irq_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_miss(ev_miss), .ev_rx_first(ev_rx_first), .ev_rx_last(ev_rx_last),
        .ev_tx_done(ev_tx_done), .ev_tx_ok(ev_tx_ok), .ev_init_done(ev_init_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    // m = {init, tx_ok, tx_done, rx_last, rx_first, miss}
    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        {ev_init_done, ev_tx_ok, ev_tx_done, ev_rx_last, ev_rx_first, ev_miss} = m;
        @(negedge clk);
        {ev_init_done, ev_tx_ok, ev_tx_done, ev_rx_last, ev_rx_first, ev_miss} = '0;
    endtask

    function automatic logic [4:0] st(input logic [31:0] v);
        return v[12:8];
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 32'h0);
        rd(2'd1, v); check("R1 cfg", v, 32'h0);
        rd(2'd2, v); check("R1 tmo", v, 32'd153600);
        check("R1 irq_n", {31'b0, irq_n}, 32'd1);
    endtask

    task automatic t_sources();
        logic [31:0] v;
        pulse(6'b100000); rd(2'd0, v); check("R10 idon", {27'b0, st(v)}, 32'h01);
        pulse(6'b000001); rd(2'd0, v); check("R10 miss", {27'b0, st(v)}, 32'h11);
        wr(2'd0, 32'h0000_1100); rd(2'd0, v); check("R2 w1c", {27'b0, st(v)}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(6'b100100);                        // init + rx_last
        wr(2'd0, 32'h0000_0000); rd(2'd0, v);
        check("R2 write0 keeps", {27'b0, st(v)}, 32'h05);
        wr(2'd0, 32'h0000_0400); rd(2'd0, v);
        check("R2 w1c one bit", {27'b0, st(v)}, 32'h01);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk);
        ev_init_done = 1; wr_en = 1; wr_addr = 2'd0; wr_data = 32'h0000_0100;
        @(negedge clk);
        ev_init_done = 0; wr_en = 0; wr_data = '0;
        rd(2'd0, v); check("R3 set beats clear", {27'b0, st(v)}, 32'h01);
        wr(2'd0, 32'h0000_0100);
    endtask

    task automatic t_stop_soft();
        logic [31:0] v;
        pulse(6'b100101);
        wr(2'd0, 32'h0000_0002); rd(2'd0, v);
        check("R4 stop clears", {27'b0, st(v)}, 32'h0);
        pulse(6'b010101);
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0;
        rd(2'd0, v); check("R4 soft reset clears", {27'b0, st(v)}, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        pulse(6'b100000);
        check("R5 enable off keeps irq_n high", {31'b0, irq_n}, 32'd1);
        rd(2'd0, v); check("R6 pending without enable", {31'b0, v[2]}, 32'd1);
        @(negedge clk); wr_en = 1; wr_addr = 2'd0; wr_data = 32'h1;
        @(negedge clk); wr_en = 0; wr_data = '0;
        check("R5 one cycle latency", {31'b0, irq_n}, 32'd1);
        @(negedge clk);
        check("R5 irq asserted", {31'b0, irq_n}, 32'd0);
        wr(2'd1, 32'h0000_0100);
        @(negedge clk);
        check("R5 masked source", {31'b0, irq_n}, 32'd1);
        rd(2'd0, v); check("R6 pending masked", {31'b0, v[2]}, 32'd0);
        pulse(6'b000100);   // rx_last, bit 10 unmasked
        @(negedge clk);
        check("R5 other source", {31'b0, irq_n}, 32'd0);
        wr(2'd0, 32'h0000_1F01);
        wr(2'd1, 32'h0);
        @(negedge clk);
        check("R5 cleared", {31'b0, irq_n}, 32'd1);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_err();
        logic [31:0] v;
        wr(2'd1, 32'h0000_1F00);
        pulse(6'b000001); rd(2'd0, v);
        check("R7 err with masks", {30'b0, v[3:2]}, 32'h2);
        wr(2'd0, 32'h0000_1000); rd(2'd0, v);
        check("R7 err clears", {31'b0, v[3]}, 32'd0);
        pulse(6'b100000); rd(2'd0, v);
        check("R7 idon no err", {31'b0, v[3]}, 32'd0);
        wr(2'd0, 32'h0000_0100);
        wr(2'd1, 32'h0);
    endtask

    task automatic t_rint();
        logic [31:0] v;
        pulse(6'b000010); rd(2'd0, v);
        check("R8 first ignored", {27'b0, st(v)}, 32'h0);
        wr(2'd1, 32'h1);
        pulse(6'b000010); rd(2'd0, v);
        check("R8 early report", {27'b0, st(v)}, 32'h04);
        wr(2'd0, 32'h0000_0400); wr(2'd1, 32'h0);
    endtask

    task automatic t_tint();
        logic [31:0] v;
        pulse(6'b011000); rd(2'd0, v);
        check("R9 ok not suppressed", {27'b0, st(v)}, 32'h02);
        wr(2'd0, 32'h0000_0200); wr(2'd1, 32'h2);
        pulse(6'b011000); rd(2'd0, v);
        check("R9 ok suppressed", {27'b0, st(v)}, 32'h0);
        pulse(6'b001000); rd(2'd0, v);
        check("R9 error reported", {27'b0, st(v)}, 32'h02);
        wr(2'd0, 32'h0000_0200); wr(2'd1, 32'h0);
    endtask

    task automatic t_watchdog();
        logic [31:0] v;
        wr(2'd2, 32'd2);   // 2 us = 250 cycles at 125 MHz
        @(negedge clk); bus_req = 1;
        repeat (240) @(negedge clk);
        rd(2'd0, v); check("R11 before limit", {31'b0, v[11]}, 32'd0);
        repeat (20) @(negedge clk);
        rd(2'd0, v); check("R11 after limit", {28'b0, v[11], 3'b0} | {31'b0, v[3]}, 32'h9);
        wr(2'd0, 32'h0000_0800);
        repeat (300) @(negedge clk);
        rd(2'd0, v); check("R11 once per wait", {31'b0, v[11]}, 32'd0);
        bus_req = 0;
        @(negedge clk); bus_req = 1;
        repeat (200) @(negedge clk);
        bus_gnt = 1; @(negedge clk); bus_gnt = 0;
        repeat (200) @(negedge clk);
        rd(2'd0, v); check("R11 grant restarts", {31'b0, v[11]}, 32'd0);
        repeat (60) @(negedge clk);
        rd(2'd0, v); check("R11 fires after restart", {31'b0, v[11]}, 32'd1);
        bus_req = 0;
        wr(2'd0, 32'h0000_0800);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sources();
        t_w1c();
        t_set_wins();
        t_stop_soft();
        t_irq();
        t_err();
        t_rint();
        t_tint();
        t_watchdog();
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end
endmodule